// File: doc/BRIEF.md
# Armed Double-Buffered Display Register Bank

This bank holds the per-plane settings of a display pipe in two copies. Software writes reach only the pending copy. The scan-out logic reads only the active copy. The watermark registers need an explicit arming step. Writing them only stages new values. The staged group becomes eligible to move only after software writes the surface base register, which acts as the trigger. At the next latch event the whole group, trigger included, is copied to active in one clock. A latch event is either a vertical-blank-start pulse or the first cycle in which the plane enable is seen high.

A frame counter steps on every vertical-blank-start pulse that arrives while the plane is enabled. Software uses it to confirm that a new setting has landed: write the watermarks, write the surface base, then wait for the count to change. For older pipes, a build parameter makes the watermark registers single-buffered. In that mode a watermark write takes effect at once, while the surface register keeps its armed behaviour.

Top module: `dbuf_reg_bank`

## Requirements
- R1: After reset, every pending and active register reads zero, `armed` is 0 and `frame_count` is 0.
- R2: A write to a watermark register (addresses 0 to NUM_WM-1) changes only its pending copy. The active copy and `active_wm` are unchanged.
- R3: A vertical-blank-start pulse while `armed` is 0 leaves all active values unchanged.
- R4: A write to the surface register (address NUM_WM) stores the value in the pending surface copy and sets `armed` in the next cycle.
- R5: When `armed` is 1 and `vblank_start` is pulsed, every pending register, watermarks and surface alike, is copied to active in that same clock edge, and `armed` clears.
- R6: When `armed` is 1 and `plane_en` goes from 0 to 1, the group is latched exactly as in R5.
- R7: Pending writes made while armed and before the latch are the values that get latched. `armed` stays set until the latch.
- R8: `frame_count` increments by one on each `vblank_start` pulse that arrives while `plane_en` is 1. It holds otherwise, and it wraps to zero after its all-ones value.
- R9: `rd_data` returns the pending copy of register `rd_addr` when `rd_active` is 0, and the active copy when it is 1. Unused addresses read zero.
- R10: If a surface write falls in the same cycle as an armed latch event, the previous pending values are latched and the new surface value stays pending, with `armed` still 1.
- R11: With LEGACY_WM=1, a watermark write updates the active copy at the same clock edge as the pending copy, without arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register index |
| wr_data | input | DATA_W | Write value |
| rd_addr | input | ADDR_W | Read register index |
| rd_active | input | 1 | 1 reads the active copy, 0 reads the pending copy |
| rd_data | output | DATA_W | Read value (combinational) |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| plane_en | input | 1 | Pipe/plane enable level |
| active_wm | output | NUM_WM*DATA_W | Active watermark values, register i in bits [i*DATA_W +: DATA_W] |
| active_surf | output | DATA_W | Active surface base value |
| armed | output | 1 | A staged group is waiting for a latch event |
| frame_count | output | FCNT_W | Frames seen while enabled |

## Verification
An arming write to the surface register can coincide with a latch event that consumes an earlier arming. The bench provokes this by asserting a surface write and `vblank_start` in the same cycle while the bank is already armed. It then judges three things: the active surface takes the older pending value, the read-back pending copy holds the new one, and `armed` remains set. A second vblank then delivers the newer value and clears `armed`. The two ways of latching are also exercised separately, so that a rising plane enable and a vblank pulse are each shown to commit on their own.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [0:0] {SLOT_DOUBLE = 1'b0, SLOT_SINGLE = 1'b1} slot_mode_e;

  // A new arming request always wins over the clearing done by a commit.
  function automatic logic arm_next(input logic armed_q, input logic commit,
                                    input logic arm_req);
    return arm_req | (armed_q & ~commit);
  endfunction

  // A latch event is a vblank start or the first cycle the plane is seen enabled.
  function automatic logic latch_event(input logic vblank, input logic en,
                                       input logic en_q);
    return vblank | (en & ~en_q);
  endfunction
endpackage

// File: rtl/dbuf_slot.sv
module dbuf_slot
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter slot_mode_e MODE = SLOT_DOUBLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] act
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else if (wr_hit) pend <= wr_data;
  end

  generate
    if (MODE == SLOT_SINGLE) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else if (wr_hit) act <= wr_data;
      end
    end else begin : g_double
      always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else if (commit) act <= pend;
      end
    end
  endgenerate
endmodule

// File: rtl/dbuf_arm_ctrl.sv
module dbuf_arm_ctrl
  import dbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic vblank_start,
  input  logic plane_en,
  output logic armed,
  output logic latch_evt,
  output logic commit
);
  logic en_q;

  assign latch_evt = latch_event(vblank_start, plane_en, en_q);
  assign commit    = armed & latch_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      armed <= 1'b0;
    end else begin
      en_q  <= plane_en;
      armed <= arm_next(armed, commit, arm_req);
    end
  end
endmodule

// File: rtl/dbuf_frame_ctr.sv
module dbuf_frame_ctr #(
  parameter int FCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_start,
  input  logic              plane_en,
  output logic [FCNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (vblank_start && plane_en) count <= count + FCNT_W'(1);
  end
endmodule

// File: rtl/dbuf_reg_bank.sv
module dbuf_reg_bank
  import dbuf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WM    = 4,
  parameter int ADDR_W    = 3,
  parameter int FCNT_W    = 32,
  parameter bit LEGACY_WM = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     rd_active,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     vblank_start,
  input  logic                     plane_en,
  output logic [NUM_WM*DATA_W-1:0] active_wm,
  output logic [DATA_W-1:0]        active_surf,
  output logic                     armed,
  output logic [FCNT_W-1:0]        frame_count
);
  localparam int NSLOT    = NUM_WM + 1;
  localparam int SURF_IDX = NUM_WM;
  localparam slot_mode_e WM_MODE = LEGACY_WM ? SLOT_SINGLE : SLOT_DOUBLE;

  logic [DATA_W-1:0] pend_arr [NSLOT];
  logic [DATA_W-1:0] act_arr  [NSLOT];
  logic [NSLOT-1:0]  wr_hit;
  logic              arm_req;
  logic              latch_evt;
  logic              commit;
  logic [DATA_W-1:0] pend_surf;

  assign arm_req   = wr_hit[SURF_IDX];
  assign pend_surf = pend_arr[SURF_IDX];

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      localparam slot_mode_e SMODE = (gi == SURF_IDX) ? SLOT_DOUBLE : WM_MODE;
      assign wr_hit[gi] = wr_en && (wr_addr == ADDR_W'(gi));
      dbuf_slot #(.DATA_W(DATA_W), .MODE(SMODE)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit[gi]),
        .wr_data (wr_data),
        .commit  (commit),
        .pend    (pend_arr[gi]),
        .act     (act_arr[gi])
      );
      if (gi < NUM_WM) begin : g_out
        assign active_wm[gi*DATA_W +: DATA_W] = act_arr[gi];
      end
    end
  endgenerate

  assign active_surf = act_arr[SURF_IDX];

  dbuf_arm_ctrl u_arm (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_req      (arm_req),
    .vblank_start (vblank_start),
    .plane_en     (plane_en),
    .armed        (armed),
    .latch_evt    (latch_evt),
    .commit       (commit)
  );

  dbuf_frame_ctr #(.FCNT_W(FCNT_W)) u_fcnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .plane_en     (plane_en),
    .count        (frame_count)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = rd_active ? act_arr[i] : pend_arr[i];
    end
  end
endmodule

// File: rtl/dbuf_reg_bank_chk.sv
module dbuf_reg_bank_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_WM = 4,
  parameter int ADDR_W = 3,
  parameter int FCNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              vblank_start,
  input logic              plane_en,
  input logic              armed,
  input logic              commit,
  input logic              arm_req,
  input logic [DATA_W-1:0] active_surf,
  input logic [DATA_W-1:0] pend_surf,
  input logic [FCNT_W-1:0] frame_count
);
  AST_ARM_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(NUM_WM)) |=> armed); // R4
  AST_DISARM_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !arm_req) |=> !armed); // R5
  AST_SURF_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_surf == $past(pend_surf))); // R5
  AST_SURF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_surf)); // R3
  AST_ARMED_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !commit) |=> armed); // R7
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && plane_en) |=> (frame_count == $past(frame_count) + FCNT_W'(1))); // R8
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_start && plane_en) |=> $stable(frame_count)); // R8
endmodule

bind dbuf_reg_bank dbuf_reg_bank_chk #(
  .DATA_W(DATA_W), .NUM_WM(NUM_WM), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .vblank_start (vblank_start),
  .plane_en     (plane_en),
  .armed        (armed),
  .commit       (commit),
  .arm_req      (arm_req),
  .active_surf  (active_surf),
  .pend_surf    (pend_surf),
  .frame_count  (frame_count)
);

// File: tb/test_dbuf_reg_bank.sv
`timescale 1ns/1ps
module test_dbuf_reg_bank;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int AW = 3;
  localparam logic [AW-1:0] SURF = AW'(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_active = 1'b0;
  logic vblank_start = 1'b0;
  logic plane_en = 1'b0;
  logic [DW-1:0] rd_data, lg_rd_data;
  logic [NW*DW-1:0] active_wm, lg_active_wm;
  logic [DW-1:0] active_surf, lg_active_surf;
  logic armed, lg_armed;
  logic [31:0] frame_count;
  logic [3:0] lg_frame_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbuf_reg_bank #(.DATA_W(DW), .NUM_WM(NW), .ADDR_W(AW), .FCNT_W(32), .LEGACY_WM(1'b0))
  i_dbuf_reg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(rd_data),
    .vblank_start(vblank_start), .plane_en(plane_en), .active_wm(active_wm),
    .active_surf(active_surf), .armed(armed), .frame_count(frame_count)
  );

  dbuf_reg_bank #(.DATA_W(DW), .NUM_WM(NW), .ADDR_W(AW), .FCNT_W(4), .LEGACY_WM(1'b1))
  i_legacy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_active(rd_active), .rd_data(lg_rd_data),
    .vblank_start(vblank_start), .plane_en(plane_en), .active_wm(lg_active_wm),
    .active_surf(lg_active_surf), .armed(lg_armed), .frame_count(lg_frame_count)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic vblank();
    @(negedge clk);
    vblank_start = 1'b1;
    @(negedge clk);
    vblank_start = 1'b0;
  endtask

  function automatic logic [DW-1:0] wm(input logic [NW*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic act_sel,
                        input logic [DW-1:0] exp);
    rd_addr = a; rd_active = act_sel;
    #1;
    check(req, "read", rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1", "armed", 32'(armed), 0);
    check("R1", "frame", frame_count, 0);
    check("R1", "active_surf", active_surf, 0);
    rd_chk("R1", 0, 1'b0, 0);
    rd_chk("R1", SURF, 1'b1, 0);
  endtask

  task automatic t_pending_only();
    wr(0, 32'hA1);
    rd_chk("R2", 0, 1'b0, 32'hA1);
    check("R2", "active_wm0", wm(active_wm, 0), 0);
    rd_chk("R9", 0, 1'b1, 0);
    rd_chk("R9", 3'd7, 1'b0, 0);
    check("R2", "armed", 32'(armed), 0);
  endtask

  task automatic t_vblank_unarmed();
    vblank();
    check("R3", "active_wm0", wm(active_wm, 0), 0);
    check("R8", "frame while disabled", frame_count, 0);
  endtask

  task automatic t_arm_vblank();
    wr(1, 32'hB2);
    wr(SURF, 32'hC3);
    check("R4", "armed", 32'(armed), 1);
    check("R4", "active_surf before latch", active_surf, 0);
    wr(0, 32'hA5);
    check("R7", "still armed", 32'(armed), 1);
    vblank();
    check("R5", "active_wm0", wm(active_wm, 0), 32'hA5);
    check("R5", "active_wm1", wm(active_wm, 1), 32'hB2);
    check("R5", "active_surf", active_surf, 32'hC3);
    check("R5", "armed cleared", 32'(armed), 0);
    rd_chk("R9", 1, 1'b1, 32'hB2);
  endtask

  task automatic t_enable_latch();
    @(negedge clk); plane_en = 1'b1;
    @(negedge clk);
    vblank();
    check("R8", "frame step", frame_count, 1);
    @(negedge clk); plane_en = 1'b0;
    wr(2, 32'hD4);
    wr(SURF, 32'hE5);
    check("R6", "active_wm2 before enable", wm(active_wm, 2), 0);
    @(negedge clk); plane_en = 1'b1;
    @(negedge clk);
    check("R6", "active_wm2", wm(active_wm, 2), 32'hD4);
    check("R6", "active_surf", active_surf, 32'hE5);
    check("R6", "armed cleared", 32'(armed), 0);
  endtask

  task automatic t_same_cycle();
    wr(3, 32'hF6);
    wr(SURF, 32'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = SURF; wr_data = 32'h22; vblank_start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; vblank_start = 1'b0;
    check("R10", "active_surf old", active_surf, 32'h11);
    check("R10", "active_wm3", wm(active_wm, 3), 32'hF6);
    check("R10", "armed kept", 32'(armed), 1);
    rd_chk("R10", SURF, 1'b0, 32'h22);
    check("R8", "frame", frame_count, 2);
    vblank();
    check("R10", "active_surf new", active_surf, 32'h22);
    check("R10", "armed cleared", 32'(armed), 0);
    check("R8", "frame", frame_count, 3);
  endtask

  task automatic t_legacy();
    wr(0, 32'h77);
    check("R11", "legacy active_wm0", wm(lg_active_wm, 0), 32'h77);
    check("R2", "double active_wm0 unchanged", wm(active_wm, 0), 32'hA5);
    check("R11", "legacy armed", 32'(lg_armed), 0);
    for (int k = 0; k < 16; k++) vblank();
    check("R8", "frame 32b", frame_count, 19);
    check("R8", "wrap 4b", 32'(lg_frame_count), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending_only();
    t_vblank_unarmed();
    t_arm_vblank();
    t_enable_latch();
    t_same_cycle();
    t_legacy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule